// File: doc/BRIEF.md
# FPGA configuration control sequencer

This block sits on the host side of an FPGA and runs its configuration control lines. On a start command it turns on the FPGA power rails. It then drives the program line low for a guaranteed minimum width. It waits for the FPGA to finish clearing its configuration memory, which it sees as a rising edge on the init line. If asked, it holds the init line low until the boot PROM has had time to wake. Finally it waits for the done indication.

While the FPGA loads, a low level on the init line is reported as a CRC error. Watchdog counters guard the two waits on the FPGA, and each one ends the sequence in an error state with a sticky timeout flag.

A separate hold input keeps the program line low for as long as it is asserted. This leaves the FPGA pins high-impedance so that the configuration flash can be reached directly. The program and init lines are open-drain, so the block presents a drive-low enable for each and reads their levels back through two-flop synchronizers. The status is an 8-byte reply vector that a command handler can return as is.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset the state code is IDLE (0), the power enable and both drive-low enables are low, and the status reply is all zero.
- R2: A start pulse with the hold input low, in any state other than HOLD_PROG, moves to POWER_ON (code 1) on the next clock edge. The power enable rises on that same edge and then stays high until reset.
- R3: After POWER_ON the program drive-low enable is high for exactly ceil(PROG_NS * CLK_HZ / 1e9) consecutive cycles, with PROG_NS raised to 500 when set lower. It is not driven outside this pulse except in hold mode.
- R4: After the pulse, the block advances only when the synchronized init input has been seen low and is then high, in state WAIT_INIT_HIGH (code 3). If INIT_TIMEOUT_CYC cycles pass in that state first, it enters ERROR (code 7) and sets the init-timeout flag.
- R5: When the PROM wake-up input is high and fewer than ceil(PROM_WAIT_US * CLK_HZ / 1e6) cycles have passed since the power enable rose, the init drive-low enable is held high after the pulse (state PROM_WAIT, code 4). It is released only once that many cycles have passed.
- R6: Once clearing has finished, a low synchronized init level during WAIT_DONE (code 5) sets the CRC-error flag and enters ERROR.
- R7: A high synchronized done input in WAIT_DONE enters CONFIGURED (code 6). If DONE_TIMEOUT_CYC cycles pass first, the block enters ERROR and sets the done-timeout flag.
- R8: The reply layout is fixed:
  - byte 0 holds the state code;
  - byte 1 bit 2 is done-timeout, bit 1 is init-timeout and bit 0 is CRC-error;
  - byte 4 bit 0 is the synchronized done level;
  - every other bit is zero.
  The flags are sticky and are cleared only by an accepted start or by reset.
- R9: A high hold input forces HOLD_PROG (code 8) on the next edge from any state, even when start is high in the same cycle. The program drive-low enable stays high for as long as the block is in HOLD_PROG, and start is ignored there. Dropping the hold input returns the block to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or restart the configuration sequence |
| hold_prog_i | input | 1 | Keep the program line low for direct flash access |
| prom_wait_en_i | input | 1 | Hold init low until the PROM wake-up time has passed |
| init_pin_i | input | 1 | Level read back from the init line |
| done_pin_i | input | 1 | Level read back from the done line |
| pwr_en_o | output | 1 | Power-rail enable |
| drive_low_prog_o | output | 1 | Pull the program line low |
| drive_low_init_o | output | 1 | Pull the init line low |
| status_reply_o | output | 64 | Eight-byte status reply, byte 0 in bits 7:0 |

## Verification
The bench builds the block with a 200 MHz CLK_HZ and a 500 ns PROG_NS, which gives a 100-cycle program pulse. PROM_WAIT_US is cut to 10, so the wake-up hold lasts 2000 cycles, and the two timeouts are set to 1000 and 1500 cycles. These values let a single run see the PROM hold on the first start, both timeout paths, a CRC failure and a restart in mid-pulse. They also leave room for many randomized complete configurations, each with its own clearing and loading delays. The bench models the FPGA as open-drain lines that it pulls low during clearing and on an injected CRC error.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_POWER_ON   = 4'd1,
        ST_PROG_PULSE = 4'd2,
        ST_WAIT_INIT  = 4'd3,
        ST_PROM_WAIT  = 4'd4,
        ST_WAIT_DONE  = 4'd5,
        ST_CONFIGURED = 4'd6,
        ST_ERROR      = 4'd7,
        ST_HOLD_PROG  = 4'd8
    } cfg_state_e;

    typedef struct packed {
        logic to_done;
        logic to_init;
        logic crc_err;
    } cfg_flags_t;

    localparam int unsigned REPLY_BYTES = 8;
    localparam int unsigned MIN_PROG_NS = 500;

    function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                 input longint unsigned ns);
        return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                                 input longint unsigned us);
        return int'((hz * us + 64'd999_999) / 64'd1_000_000);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [REPLY_BYTES*8-1:0] build_reply(input cfg_state_e st,
                                                             input cfg_flags_t fl,
                                                             input logic done_lvl);
        logic [REPLY_BYTES*8-1:0] r;
        r = '0;
        r[3:0]  = st;
        r[10:8] = fl;
        r[32]   = done_lvl;
        return r;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk) begin
            if (rst) stage <= 2'b00;
            else     stage <= {stage[0], async_i[g]};
        end
        assign sync_o[g] = stage[1];
    end
endmodule

// File: rtl/cfg_pwr_timer.sv
module cfg_pwr_timer #(
    parameter int unsigned PROM_CYC = 400_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req_i,
    output logic pwr_en_o,
    output logic elapsed_o
);
    localparam int unsigned CW = (PROM_CYC < 1) ? 1 : $clog2(PROM_CYC + 1);

    logic [CW-1:0] since_pwr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_en_o  <= 1'b0;
            since_pwr <= '0;
        end else begin
            if (pwr_req_i) pwr_en_o <= 1'b1;
            if (pwr_en_o && (since_pwr < CW'(PROM_CYC))) since_pwr <= since_pwr + 1'b1;
        end
    end

    assign elapsed_o = (since_pwr >= CW'(PROM_CYC));

    // R2: once the rails are on they stay on
    a_r2_pwr_sticky: assert property (@(posedge clk) disable iff (rst)
        pwr_en_o |=> pwr_en_o);
    // R5: the wake-up window never reopens
    a_r5_elapsed_sticky: assert property (@(posedge clk) disable iff (rst)
        elapsed_o |=> elapsed_o);
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import fpga_cfg_pkg::*;
#(
    parameter int unsigned PROG_CYC  = 100,
    parameter int unsigned INIT_TO   = 1000,
    parameter int unsigned DONE_TO   = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       hold_i,
    input  logic       prom_en_i,
    input  logic       elapsed_i,
    input  logic       init_s_i,
    input  logic       done_s_i,
    output logic       pwr_req_o,
    output logic       drive_low_prog_o,
    output logic       drive_low_init_o,
    output cfg_state_e state_o,
    output cfg_flags_t flags_o
);
    localparam int unsigned CNT_MAX = max3(PROG_CYC, INIT_TO, DONE_TO);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    cfg_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             seen_low;
    logic             go, set_to_init, set_to_done, set_crc;

    always_comb begin
        nxt         = state;
        set_to_init = 1'b0;
        set_to_done = 1'b0;
        set_crc     = 1'b0;
        unique case (state)
            ST_POWER_ON:   nxt = ST_PROG_PULSE;
            ST_PROG_PULSE: if (cnt == CNT_W'(PROG_CYC - 1))
                               nxt = (prom_en_i && !elapsed_i) ? ST_PROM_WAIT : ST_WAIT_INIT;
            ST_PROM_WAIT:  if (elapsed_i) nxt = ST_WAIT_INIT;
            ST_WAIT_INIT: begin
                if (seen_low && init_s_i) nxt = ST_WAIT_DONE;
                else if (cnt == CNT_W'(INIT_TO - 1)) begin
                    nxt = ST_ERROR;
                    set_to_init = 1'b1;
                end
            end
            ST_WAIT_DONE: begin
                if (!init_s_i) begin
                    nxt = ST_ERROR;
                    set_crc = 1'b1;
                end else if (done_s_i) nxt = ST_CONFIGURED;
                else if (cnt == CNT_W'(DONE_TO - 1)) begin
                    nxt = ST_ERROR;
                    set_to_done = 1'b1;
                end
            end
            ST_HOLD_PROG:  if (!hold_i) nxt = ST_IDLE;
            default:       nxt = state;
        endcase
        go = 1'b0;
        if (state != ST_HOLD_PROG) begin
            if (hold_i) begin
                nxt = ST_HOLD_PROG;
                set_to_init = 1'b0;
                set_to_done = 1'b0;
                set_crc     = 1'b0;
            end else if (start_i) begin
                nxt = ST_POWER_ON;
                go  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            seen_low <= 1'b0;
            flags_o  <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
            if (state == ST_POWER_ON) seen_low <= 1'b0;
            else if (!init_s_i && (state == ST_PROG_PULSE || state == ST_PROM_WAIT ||
                                   state == ST_WAIT_INIT)) seen_low <= 1'b1;
            if (go) flags_o <= '0;
            else begin
                if (set_to_init) flags_o.to_init <= 1'b1;
                if (set_to_done) flags_o.to_done <= 1'b1;
                if (set_crc)     flags_o.crc_err <= 1'b1;
            end
        end
    end

    assign pwr_req_o        = go;
    assign drive_low_prog_o = (state == ST_PROG_PULSE) || (state == ST_HOLD_PROG);
    assign drive_low_init_o = (state == ST_PROM_WAIT);
    assign state_o          = state;

    // R2: an accepted start restarts the sequence
    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && !hold_i && state != ST_HOLD_PROG) |=> (state == ST_POWER_ON));
    // R9: hold wins and keeps program low; start is ignored while holding
    a_r9_hold_enter: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (state == ST_HOLD_PROG) && drive_low_prog_o);
    // R7: configured only after done was seen
    a_r7_done_seen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_DONE && nxt == ST_CONFIGURED) |-> done_s_i);
    // R5: init released from the wake-up hold only after the window elapsed
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (drive_low_init_o && !hold_i && !start_i) |=> (drive_low_init_o || $past(elapsed_i)));
    // R8: flags stay put unless a start is accepted
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        (!go && flags_o != 3'b000) |=> (flags_o & $past(flags_o)) == $past(flags_o));
    // R4: advancing past clearing requires init high
    a_r4_init_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_INIT && nxt == ST_WAIT_DONE) |-> init_s_i);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import fpga_cfg_pkg::*;
#(
    parameter longint unsigned CLK_HZ           = 200_000_000,
    parameter int unsigned     PROG_NS          = 500,
    parameter int unsigned     PROM_WAIT_US     = 2000,
    parameter int unsigned     INIT_TIMEOUT_CYC = 2_000_000,
    parameter int unsigned     DONE_TIMEOUT_CYC = 20_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        hold_prog_i,
    input  logic        prom_wait_en_i,
    input  logic        init_pin_i,
    input  logic        done_pin_i,
    output logic        pwr_en_o,
    output logic        drive_low_prog_o,
    output logic        drive_low_init_o,
    output logic [63:0] status_reply_o
);
    localparam int unsigned PROG_EFF = (PROG_NS < MIN_PROG_NS) ? MIN_PROG_NS : PROG_NS;
    localparam int unsigned PROG_CYC = ns_to_cycles(CLK_HZ, 64'(PROG_EFF));
    localparam int unsigned PROM_CYC = us_to_cycles(CLK_HZ, 64'(PROM_WAIT_US));

    logic [1:0] pins_s;
    logic       pwr_req, elapsed;
    cfg_state_e state;
    cfg_flags_t flags;

    cfg_sync #(.W(2)) u_sync (
        .clk(clk), .rst(rst),
        .async_i({done_pin_i, init_pin_i}),
        .sync_o(pins_s)
    );

    cfg_pwr_timer #(.PROM_CYC(PROM_CYC)) u_pwr (
        .clk(clk), .rst(rst),
        .pwr_req_i(pwr_req),
        .pwr_en_o(pwr_en_o),
        .elapsed_o(elapsed)
    );

    cfg_fsm #(.PROG_CYC(PROG_CYC), .INIT_TO(INIT_TIMEOUT_CYC), .DONE_TO(DONE_TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst(rst),
        .start_i(start_i),
        .hold_i(hold_prog_i),
        .prom_en_i(prom_wait_en_i),
        .elapsed_i(elapsed),
        .init_s_i(pins_s[0]),
        .done_s_i(pins_s[1]),
        .pwr_req_o(pwr_req),
        .drive_low_prog_o(drive_low_prog_o),
        .drive_low_init_o(drive_low_init_o),
        .state_o(state),
        .flags_o(flags)
    );

    assign status_reply_o = build_reply(state, flags, pins_s[1]);

    // R3: program pulse only in its state or in hold, and rails on when pulsing
    a_r3_prog_needs_pwr: assert property (@(posedge clk) disable iff (rst)
        drive_low_prog_o && !hold_prog_i |-> pwr_en_o || $past(hold_prog_i));
endmodule

// File: tb/fpga_cfg_seq_tb.sv
module fpga_cfg_seq_tb_top;
    localparam int PROG_CYC = 100;
    localparam int PROM_CYC = 2000;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, hold = 0, prom_en = 0;
    logic init_pin, done_pin;
    logic pwr_en, dl_prog, dl_init;
    logic [63:0] reply;

    always #2.5 clk = ~clk;

    fpga_cfg_seq #(.CLK_HZ(200_000_000), .PROG_NS(500), .PROM_WAIT_US(10),
                   .INIT_TIMEOUT_CYC(1000), .DONE_TIMEOUT_CYC(1500)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .hold_prog_i(hold),
        .prom_wait_en_i(prom_en), .init_pin_i(init_pin), .done_pin_i(done_pin),
        .pwr_en_o(pwr_en), .drive_low_prog_o(dl_prog), .drive_low_init_o(dl_init),
        .status_reply_o(reply)
    );

    // FPGA model
    int clear_len = 50, done_len = 100, crc_after = -1;
    bit armed = 0, clearing = 0, crc_low = 0, fdone = 0;
    int mcnt = 0;
    assign init_pin = !(dl_init || clearing || crc_low);
    assign done_pin = fdone;

    always @(negedge clk) begin
        if (dl_prog) begin
            armed = 1; clearing = 1; mcnt = 0; fdone = 0; crc_low = 0;
        end else if (armed && clearing) begin
            mcnt++;
            if (mcnt >= clear_len) begin clearing = 0; mcnt = 0; end
        end else if (armed && !dl_init && !crc_low && !fdone) begin
            mcnt++;
            if (crc_after > 0 && mcnt == crc_after) crc_low = 1;
            else if (mcnt >= done_len) fdone = 1;
        end
    end

    int cyc = 0, total = 0, bad = 0;
    always @(posedge clk) cyc++;

    function automatic logic [63:0] exp_reply(int st, int fl, bit dn);
        logic [63:0] r = '0;
        r[7:0] = 8'(st); r[15:8] = 8'(fl); r[32] = dn;
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_final();
        for (int i = 0; i < 5000; i++) begin
            if (reply[7:0] == 8'd6 || reply[7:0] == 8'd7) return;
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned seed = $urandom(2024);
        int t0, w;
        tick(4); rst = 0; @(negedge clk);
        // R1 reset state
        chk("R1 reply", reply, 64'd0);
        chk("R1 outs", {61'd0, pwr_en, dl_prog, dl_init}, 64'd0);

        // first start with PROM wake-up hold
        prom_en = 1; clear_len = 50; done_len = 100;
        pulse_start();
        chk("R2 power_on", reply[7:0], 8'd1);
        chk("R2 pwr_en", pwr_en, 1);
        t0 = cyc;
        while (!dl_prog) @(negedge clk);
        w = 0;
        while (dl_prog) begin w++; @(negedge clk); end
        chk("R3 prog width", w, PROG_CYC);
        chk("R5 prom state", reply[7:0], 8'd4);
        chk("R5 init driven", dl_init, 1);
        while (dl_init) @(negedge clk);
        w = cyc - t0;
        chk("R5 prom window", (w >= PROM_CYC && w <= PROM_CYC + 2), 1);
        wait_final(); tick(3);
        chk("R7 configured", reply, exp_reply(6, 0, 1));

        // init timeout, then sticky flag
        clear_len = 100000;
        pulse_start(); tick(600);
        chk("R4 still waiting", reply[7:0], 8'd3);
        wait_final();
        chk("R4 init timeout", reply, exp_reply(7, 2, 0));
        tick(50);
        chk("R8 flag sticky", reply, exp_reply(7, 2, 0));

        // done timeout, flags cleared by start
        clear_len = 20; done_len = 1000000;
        pulse_start();
        chk("R8 flags cleared", reply[15:0], 16'h0001);
        wait_final();
        chk("R7 done timeout", reply, exp_reply(7, 4, 0));

        // CRC error after clearing
        clear_len = 30; done_len = 200; crc_after = 50;
        pulse_start(); wait_final();
        chk("R6 crc", reply, exp_reply(7, 1, 0));
        crc_after = -1;

        // restart mid pulse
        pulse_start(); tick(20);
        chk("R3 in pulse", dl_prog, 1);
        pulse_start();
        chk("R2 restart", reply[7:0], 8'd1);
        wait_final(); tick(3);
        chk("R7 after restart", reply, exp_reply(6, 0, 1));
        chk("R2 pwr stays", pwr_en, 1);

        // hold mode, precedence over start
        @(negedge clk); hold = 1; start = 1;
        @(negedge clk); start = 0;
        chk("R9 hold state", reply[7:0], 8'd8);
        pulse_start(); tick(300);
        chk("R9 start ignored", reply[7:0], 8'd8);
        chk("R9 prog held", dl_prog, 1);
        hold = 0; @(negedge clk);
        chk("R9 release idle", reply[7:0], 8'd0);
        chk("R9 prog released", dl_prog, 0);

        // random configurations
        for (int k = 0; k < 20; k++) begin
            bit inj;
            clear_len = 1 + int'($urandom % 150);
            done_len  = 3 + int'($urandom % 400);
            prom_en   = $urandom % 2;
            inj       = ($urandom % 4) == 0;
            crc_after = inj ? 1 + int'($urandom % (done_len - 2)) : -1;
            pulse_start(); wait_final(); tick(1);
            if (inj) chk("R6 random crc", reply, exp_reply(7, 1, 0));
            else begin tick(2); chk("R7 random cfg", reply, exp_reply(6, 0, 1)); end
        end
        crc_after = -1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial if (seed_unused()) ;
    function automatic bit seed_unused(); return 0; endfunction
endmodule